// File: doc/BRIEF.md
# UV-Erasable One-Time-Write Byte Memory Controller

This block models a byte-wide memory whose cells can only be cleared by writing and set again only by a whole-array erase. The model is clocked and synthesizable. A set of digital control flags stands in for the analog levels of a real part. These are an active-low chip select, a combined output-enable and program-supply input, a flag that marks the program supply as raised, and a flag that marks an elevated level on address bit 9. From these the block decodes one of six operating modes:

- standby
- program inhibit
- program
- normal read, which also serves as verify
- identifier read-out
- output off

The data bus is split into an input byte, an output byte and an output-valid qualifier. No tristate pins are used.

A program cycle holds chip select low with the program supply raised. It commits when chip select returns high while the supply is still raised. The stored byte becomes the bitwise AND of the old contents and the input byte. A single-cycle erase strobe starts an internal address sweep that writes all-ones to every location, one per clock.

Read data is qualified after a configurable number of clock edges, which models access time. Any change of decoded mode or address withdraws the qualifier at once.

Top module: `uvprom_core`

## Requirements
- R1: With chip select low, output-enable low, program supply not raised and elevation flag clear, `dout_en` is 1 and `dout` is the byte stored at `addr`. This is both the read and the verify access.
- R2: With chip select low, output-enable high and program supply not raised, `dout_en` is 0 (output off).
- R3: With chip select high, `dout_en` is 0 whatever the output-enable and program-supply inputs are (standby).
- R4: An `erase` pulse while idle makes `erase_busy` 1 for exactly 2^ADDR_W cycles. Afterwards every location reads FFh. An `erase` pulse while busy is ignored and does not lengthen the sweep.
- R5: With the program supply raised, a chip-select low period of at least one clock, followed by chip select sampled high with the supply still raised, writes old AND `din` to `addr`. Both `addr` and `din` are taken at that edge. `dout_en` stays 0 while the supply is raised.
- R6: Programming never sets a bit: a second program cycle to a location with a 1 in `din` leaves that bit 0 if it was already 0.
- R7: With the program supply raised and chip select held high, no location changes, whatever `addr` and `din` carry.
- R8: In identifier mode (read conditions with the elevation flag set), `dout` is 20h when `addr[0]`=0 and 0Dh when `addr[0]`=1. Other address bits have no effect.
- R9: When the decoded mode or `addr` differs from the values captured at the last clock edge, `dout_en` is 0 in that same cycle. It becomes 1 exactly ACC_LAT edges after the edge that first captured the new values.
- R10: While `erase_busy` is 1, `dout_en` is 0 and program commits are discarded.
- R11: During reset, `dout_en` and `erase_busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low, when program supply not raised |
| vpp_hi | input | 1 | Output-enable pin held at programming level |
| a9_hv | input | 1 | Elevated level present on address bit 9 |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Byte to program |
| erase | input | 1 | Whole-array erase strobe |
| dout | output | DATA_W | Read or identifier byte, zero when not qualified |
| dout_en | output | 1 | Output bus driven (valid) |
| erase_busy | output | 1 | Erase sweep in progress |

## Verification
The bench goes after the following corner cases and the failure each one exposes:

- **AND rule on reprogramming.** A design that overwrote instead of ANDing would return the new byte rather than the bit-intersection.
- **Inhibit with shifting address and data.** A design that decoded program mode without looking at chip select would corrupt the location.
- **Commit attempted in the middle of an erase.** A design that let it through would leave address 0 at 00h after the sweep.
- **Second erase strobe during the sweep.** A design that restarted the sweep would stretch the busy count beyond the array depth.
- **Cycle-exact timing of the output qualifier after an address change.** A design that checked it one edge early or late, or that failed to drop it in the change cycle, would miss the expected pattern.
- **Identifier with unrelated address bits set.** A design that decoded more than bit 0 would return the wrong code.

// File: rtl/uvprom_pkg.sv
package uvprom_pkg;

  typedef enum logic [2:0] {
    MD_STANDBY = 3'd0,
    MD_INHIBIT = 3'd1,
    MD_PROGRAM = 3'd2,
    MD_READ    = 3'd3,
    MD_IDENT   = 3'd4,
    MD_QUIET   = 3'd5
  } mode_e;

  localparam logic [7:0] MFG_CODE = 8'h20;
  localparam logic [7:0] DEV_CODE = 8'h0D;

endpackage

// File: rtl/uvprom_mode_dec.sv
module uvprom_mode_dec
  import uvprom_pkg::*;
(
  input  logic  ce_n,
  input  logic  oe_n,
  input  logic  vpp_hi,
  input  logic  a9_hv,
  output mode_e mode
);

  always_comb begin
    if (ce_n) begin
      mode = vpp_hi ? MD_INHIBIT : MD_STANDBY;
    end else if (vpp_hi) begin
      mode = MD_PROGRAM;
    end else if (oe_n) begin
      mode = MD_QUIET;
    end else if (a9_hv) begin
      mode = MD_IDENT;
    end else begin
      mode = MD_READ;
    end
  end

endmodule

// File: rtl/uvprom_array.sv
module uvprom_array
  import uvprom_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_e             mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              erase,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;

  logic              busy_q, busy_d;
  logic [ADDR_W-1:0] wipe_q, wipe_d;
  logic              was_prog_q, was_prog_d;

  logic              commit;
  logic              we;
  logic [ADDR_W-1:0] wa;
  logic [DATA_W-1:0] wd;

  // Next-state logic: erase sweep, program-edge detection, write port mux.
  always_comb begin
    if (busy_q) begin
      busy_d = (wipe_q != LAST_ADDR);
      wipe_d = wipe_q + 1'b1;
    end else begin
      busy_d = erase;
      wipe_d = '0;
    end
    was_prog_d = (mode == MD_PROGRAM);
    // Rising chip select with supply still raised ends the program pulse.
    commit = was_prog_q && (mode == MD_INHIBIT) && !busy_q;
    we     = busy_q || commit;
    wa     = busy_q ? wipe_q : addr;
    wd     = busy_q ? {DATA_W{1'b1}} : (mem[addr] & din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      wipe_q     <= '0;
      was_prog_q <= 1'b0;
    end else begin
      busy_q     <= busy_d;
      wipe_q     <= wipe_d;
      was_prog_q <= was_prog_d;
    end
  end

  // Storage array: no reset, explicit write enable.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[wa] <= wd;
    end
    rd_q <= mem[addr];
  end

  assign rd_data = rd_q;
  assign busy    = busy_q;

endmodule

// File: rtl/uvprom_read_path.sv
module uvprom_read_path
  import uvprom_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 8,
  parameter int ACC_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_e             mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              busy,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  localparam int CW = $clog2(ACC_LAT + 1);
  localparam logic [CW-1:0] LAT_MAX = CW'(ACC_LAT);

  mode_e             mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              changed;
  logic              showing;
  logic [DATA_W-1:0] value;

  always_comb begin
    changed = (mode != mode_q) || (addr != addr_q);
    if (changed || busy) begin
      cnt_d = '0;
    end else if (cnt_q != LAT_MAX) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
    showing = (mode_q == MD_READ) || (mode_q == MD_IDENT);
    dout_en = showing && !changed && !busy && (cnt_q == LAT_MAX);
    if (mode_q == MD_IDENT) begin
      value = addr_q[0] ? DATA_W'(DEV_CODE) : DATA_W'(MFG_CODE);
    end else begin
      value = rd_data;
    end
    dout = dout_en ? value : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_STANDBY;
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode;
      addr_q <= addr;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/uvprom_core.sv
module uvprom_core
  import uvprom_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 8,
  parameter int ACC_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              a9_hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              erase,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              erase_busy
);

  mode_e             mode;
  logic [DATA_W-1:0] rd_data;
  logic              busy;

  uvprom_mode_dec u_dec (
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .vpp_hi (vpp_hi),
    .a9_hv  (a9_hv),
    .mode   (mode)
  );

  uvprom_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .addr    (addr),
    .din     (din),
    .erase   (erase),
    .rd_data (rd_data),
    .busy    (busy)
  );

  uvprom_read_path #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .ACC_LAT (ACC_LAT)
  ) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .addr    (addr),
    .rd_data (rd_data),
    .busy    (busy),
    .dout    (dout),
    .dout_en (dout_en)
  );

  assign erase_busy = busy;

endmodule

// File: rtl/uvprom_core_chk.sv
module uvprom_core_chk
  import uvprom_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              vpp_hi,
  input logic              a9_hv,
  input logic [ADDR_W-1:0] addr,
  input logic              erase,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en,
  input logic              erase_busy
);

  assert_off_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n && !vpp_hi) |-> !dout_en);

  assert_standby_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dout_en);

  assert_erase_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_busy) |-> $past(erase));

  assert_prog_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_hi |-> !dout_en);

  assert_ident_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && a9_hv) |-> (dout == (addr[0] ? DATA_W'(DEV_CODE) : DATA_W'(MFG_CODE))));

  assert_settled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> ($stable(addr) && $stable(oe_n) && $stable(a9_hv)));

  assert_busy_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    erase_busy |-> !dout_en);

endmodule

bind uvprom_core uvprom_core_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce_n       (ce_n),
  .oe_n       (oe_n),
  .vpp_hi     (vpp_hi),
  .a9_hv      (a9_hv),
  .addr       (addr),
  .erase      (erase),
  .dout       (dout),
  .dout_en    (dout_en),
  .erase_busy (erase_busy)
);

// File: tb/uvprom_core_test.sv
module uvprom_core_test;

  localparam int AW    = 10;
  localparam int DW    = 8;
  localparam int LAT   = 3;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, oe_n, vpp_hi, a9_hv, erase;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          dout_en, erase_busy;

  always #10 clk = ~clk;

  uvprom_core #(.ADDR_W(AW), .DATA_W(DW), .ACC_LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .a9_hv(a9_hv), .addr(addr), .din(din), .erase(erase),
    .dout(dout), .dout_en(dout_en), .erase_busy(erase_busy)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [DW-1:0] model [DEPTH];

  bit        q_en [$];
  logic [DW-1:0] q_dat [$];
  bit        q_cd [$];
  string     q_tag [$];

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(bit en, logic [DW-1:0] d, bit cd, string tag);
    q_en.push_back(en);
    q_dat.push_back(d);
    q_cd.push_back(cd);
    q_tag.push_back(tag);
  endtask

  // Monitor: one expected item per falling edge.
  always @(negedge clk) begin
    if (q_en.size() > 0) begin
      bit e, c;
      logic [DW-1:0] d;
      string t;
      e = q_en.pop_front();
      d = q_dat.pop_front();
      c = q_cd.pop_front();
      t = q_tag.pop_front();
      n_cmp++;
      if (dout_en !== e || (c && dout !== d)) begin
        n_bad++;
        $display("FAIL %s: dout_en=%0b dout=%02h expected dout_en=%0b dout=%02h",
                 t, dout_en, dout, e, d);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drain();
    while (q_en.size() != 0) @(posedge clk);
    #1;
  endtask

  task automatic set_in(logic c, logic o, logic v, logic a9, logic [AW-1:0] a, logic [DW-1:0] d);
    ce_n = c; oe_n = o; vpp_hi = v; a9_hv = a9; addr = a; din = d;
  endtask

  // Fresh access: drop to standby, then present read conditions.
  task automatic read_expect(logic [AW-1:0] a, logic a9, logic [DW-1:0] exp, string tag);
    drain();
    set_in(1'b1, 1'b0, 1'b0, 1'b0, a, 8'h00);
    step();
    set_in(1'b0, 1'b0, 1'b0, a9, a, 8'h00);
    for (int i = 0; i <= LAT; i++) push(1'b0, 8'h00, 1'b0, {tag, " settle"});
    push(1'b1, exp, 1'b1, tag);
    drain();
  endtask

  task automatic prog(logic [AW-1:0] a, logic [DW-1:0] d);
    drain();
    set_in(1'b0, 1'b1, 1'b1, 1'b0, a, d);
    push(1'b0, 8'h00, 1'b0, "R5 program hi-z");
    push(1'b0, 8'h00, 1'b0, "R5 program hi-z");
    drain();
    ce_n = 1'b1;
    step();
    step();
    vpp_hi = 1'b0;
    step();
    model[a] = model[a] & d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int busy_cnt;
    rst_n = 1'b0;
    erase = 1'b0;
    set_in(1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
    // R11: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(dout_en == 1'b0, "R11 dout_en in reset", dout_en, 0);
      check(erase_busy == 1'b0, "R11 busy in reset", erase_busy, 0);
    end
    step();
    rst_n = 1'b1;
    step();

    // R4: erase sweep length
    erase = 1'b1;
    step();
    erase = 1'b0;
    busy_cnt = 0;
    for (int c = 0; c < DEPTH + 20; c++) begin
      @(negedge clk);
      if (erase_busy) busy_cnt++;
      if (c == 5) check(dout_en == 1'b0, "R10 no output while busy", dout_en, 0);
      step();
    end
    check(busy_cnt == DEPTH, "R4 erase duration", busy_cnt, DEPTH);
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;

    read_expect(10'h000, 1'b0, 8'hFF, "R4 erased 000");
    read_expect(10'h155, 1'b0, 8'hFF, "R4 erased 155");
    read_expect(10'h3FF, 1'b0, 8'hFF, "R4 erased 3FF");

    // R5 / R6: programming ANDs into storage
    prog(10'h012, 8'hA5);
    read_expect(10'h012, 1'b0, model[10'h012], "R5 program A5");
    prog(10'h012, 8'h0F);
    read_expect(10'h012, 1'b0, model[10'h012], "R6 bits stay cleared (05)");
    prog(10'h3FF, 8'h3C);
    read_expect(10'h3FF, 1'b0, model[10'h3FF], "R1 verify 3C");
    prog(10'h000, 8'h80);
    read_expect(10'h000, 1'b0, model[10'h000], "R1 verify 80");
    read_expect(10'h001, 1'b0, 8'hFF, "R1 neighbour untouched");

    // R2: output off
    drain();
    set_in(1'b0, 1'b1, 1'b0, 1'b0, 10'h012, 8'h00);
    for (int i = 0; i < LAT + 3; i++) push(1'b0, 8'h00, 1'b0, "R2 output off");
    drain();

    // R3: standby under both output-enable levels
    set_in(1'b1, 1'b0, 1'b0, 1'b0, 10'h012, 8'h00);
    for (int i = 0; i < LAT + 3; i++) push(1'b0, 8'h00, 1'b0, "R3 standby oe low");
    drain();
    oe_n = 1'b1;
    for (int i = 0; i < 3; i++) push(1'b0, 8'h00, 1'b0, "R3 standby oe high");
    drain();

    // R7: inhibit with shifting address and data
    set_in(1'b1, 1'b1, 1'b1, 1'b0, 10'h012, 8'h00);
    step();
    addr = 10'h3FF; din = 8'h00;
    step();
    addr = 10'h155; din = 8'h11;
    step();
    vpp_hi = 1'b0;
    step();
    read_expect(10'h012, 1'b0, model[10'h012], "R7 inhibit 012");
    read_expect(10'h3FF, 1'b0, model[10'h3FF], "R7 inhibit 3FF");
    read_expect(10'h155, 1'b0, 8'hFF, "R7 inhibit 155");

    // R8: identifier codes
    read_expect(10'h000, 1'b1, 8'h20, "R8 maker code");
    read_expect(10'h001, 1'b1, 8'h0D, "R8 device code");
    read_expect(10'h3F2, 1'b1, 8'h20, "R8 maker code, upper bits set");
    read_expect(10'h2A7, 1'b1, 8'h0D, "R8 device code, upper bits set");
    read_expect(10'h001, 1'b0, 8'hFF, "R8 array again without flag");

    // R9: direct address change while reading
    read_expect(10'h012, 1'b0, model[10'h012], "R9 start 012");
    addr = 10'h3FF;
    for (int i = 0; i <= LAT; i++) push(1'b0, 8'h00, 1'b0, "R9 latency zero");
    push(1'b1, model[10'h3FF], 1'b1, "R9 valid after latency");
    drain();
    addr = 10'h155;
    a9_hv = 1'b1;
    for (int i = 0; i <= LAT; i++) push(1'b0, 8'h00, 1'b0, "R9 latency zero ident");
    push(1'b1, 8'h0D, 1'b1, "R9 ident after latency");
    drain();

    // R4 / R10: second strobe and commit attempt during the sweep
    set_in(1'b1, 1'b1, 1'b0, 1'b0, 10'h000, 8'h00);
    step();
    erase = 1'b1;
    step();
    erase = 1'b0;
    busy_cnt = 0;
    for (int c = 0; c < DEPTH + 20; c++) begin
      @(negedge clk);
      if (erase_busy) busy_cnt++;
      step();
      case (c)
        3: erase = 1'b1;
        4: erase = 1'b0;
        6: set_in(1'b0, 1'b1, 1'b1, 1'b0, 10'h000, 8'h00);
        8: ce_n = 1'b1;
        10: vpp_hi = 1'b0;
        default: ;
      endcase
    end
    check(busy_cnt == DEPTH, "R4 restrobe ignored", busy_cnt, DEPTH);
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    read_expect(10'h000, 1'b0, 8'hFF, "R10 commit during erase dropped");
    for (int i = 1; i < DEPTH; i++) read_expect(AW'(i), 1'b0, 8'hFF, "R4 full array erased");

    drain();
    summary();
    $finish;
  end

endmodule